// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block is the host-side driver for a digital step attenuator that takes its setting over a three-wire serial link made of a data line, a clock line and a latch strobe. A client hands it a 5-bit attenuation code over a valid/ready stream port. The block prefixes a zero start bit to form a 6-bit word and shifts the word out most significant bit first. It then pulses the latch strobe so the attenuator takes the new setting.

Every edge on the three serial wires is placed by a phase counter. Each phase has a cycle count computed at elaboration from a minimum time in nanoseconds and the system clock frequency in MHz, always rounded up. Because of this, a faster or slower system clock only needs a parameter change. The block also enforces a minimum spacing between latch strobes, so the attenuator is never switched faster than 25 kHz.

Back-pressure works as follows. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` goes low in the cycle after acceptance. It stays low while the word is shifted and latched, and then until the minimum update spacing has run out. While `in_ready` is low, a client may hold `in_valid` and `in_code` steady. The held code is taken on the first edge at which `in_ready` is high again. Any code offered while `in_ready` is low is not transferred and has no effect on the serial wires.

Top module: `atten_ser_master`

## Requirements
- R1: A code is accepted only on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is low in the cycle after acceptance. A code offered while `in_ready` is low is never transmitted, and each accepted code produces exactly one serial word.
- R2: Each word has six bits, sampled by the attenuator on rising `ser_clk` edges. The first bit is 0, followed by `in_code[4]` (8 dB weight) down to `in_code[0]` (0.5 dB weight).
- R3: Every high phase and every low phase of `ser_clk` lasts at least ceil(50 ns × CLK_MHZ / 1000) cycles, which is 13 cycles at 250 MHz. This keeps the serial clock at or below 10 MHz.
- R4: `ser_data` is stable for at least ceil(10 ns) cycles (3) before each rising `ser_clk` edge. It does not change while `ser_clk` is high, or within 3 cycles after a falling edge.
- R5: `ser_le` is low while bits are being shifted. It rises only after all six bits have been clocked, and at least 3 cycles after the last falling `ser_clk` edge.
- R6: The `ser_le` high pulse lasts at least ceil(30 ns) cycles (8), and `ser_clk` is low throughout it.
- R7: Successive `ser_le` rising edges are at least ceil(40 µs) cycles (10000) apart. `in_ready` returns high exactly 10000 cycles after a `ser_le` rising edge.
- R8: While reset is asserted and whenever `in_ready` is high, `ser_clk`, `ser_data` and `ser_le` are all low. After reset, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A code is offered on `in_code` |
| in_code | input | CODE_W (5) | Attenuation code, bit 4 is the 8 dB step and bit 0 the 0.5 dB step |
| in_ready | output | 1 | The block can take a code this cycle |
| ser_clk | output | 1 | Serial shift clock to the attenuator |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_le | output | 1 | Latch strobe to the attenuator |

## Verification
The bench targets the following corner cases:
- **All-zero and all-one codes.** A shifter that drops the start bit, or sends the bits in the wrong order, produces the wrong word.
- **Alternating codes.** These force a data change between every pair of clock pulses. If data moved too early after a falling edge, or too close to the next rising edge, the hold or setup interval would be shorter than allowed.
- **A code held on `in_valid` while `in_ready` is low.** This must go out once, not twice.
- **A different code pulsed only while busy.** This must never reach the wire. A design that accepted it would latch an extra word.
- **Latch-to-latch spacing and the exact cycle when `in_ready` returns.** These are measured from the strobe. They expose a gap timer that is started at the wrong event or is off by a cycle.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_HOLD,
    ST_LESET,
    ST_LATCH
  } ser_state_e;

  // Convert a minimum time in ns to a cycle count, rounded up, never below one.
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/atten_ser_timer.sv
module atten_ser_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/atten_ser_shreg.sv
module atten_ser_shreg #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              shift,
  output logic              bit_out
);

  localparam int WORD_W = CODE_W + 1;

  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (load) begin
      sr <= {1'b0, code};
    end else if (shift) begin
      sr <= {sr[WORD_W-2:0], 1'b0};
    end
  end

  assign bit_out = sr[WORD_W-1];

endmodule

// File: rtl/atten_ser_fsm.sv
module atten_ser_fsm
  import atten_ser_pkg::*;
#(
  parameter int WORD_W   = 6,
  parameter int PH_W     = 4,
  parameter int LEAD_CYC = 10,
  parameter int HALF_CYC = 13,
  parameter int HD_CYC   = 3,
  parameter int LES_CYC  = 3,
  parameter int PW_CYC   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            gap_zero,
  input  logic            ph_zero,
  output logic            in_ready,
  output logic            accept,
  output logic            ph_load,
  output logic [PH_W-1:0] ph_val,
  output logic            shift,
  output logic            gap_load,
  output logic            sclk,
  output logic            le
);

  localparam int BC_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [PH_W-1:0] LEAD_V = PH_W'(LEAD_CYC - 1);
  localparam logic [PH_W-1:0] HALF_V = PH_W'(HALF_CYC - 1);
  localparam logic [PH_W-1:0] HD_V   = PH_W'(HD_CYC - 1);
  localparam logic [PH_W-1:0] LES_V  = PH_W'(LES_CYC - 1);
  localparam logic [PH_W-1:0] PW_V   = PH_W'(PW_CYC - 1);

  ser_state_e      state, nxt;
  logic [BC_W-1:0] bits_left;

  assign in_ready = (state == ST_IDLE) && gap_zero;
  assign accept   = in_valid && in_ready;

  always_comb begin
    nxt      = state;
    ph_load  = 1'b0;
    ph_val   = '0;
    shift    = 1'b0;
    gap_load = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          nxt     = ST_LEAD;
          ph_load = 1'b1;
          ph_val  = LEAD_V;
        end
      end
      ST_LEAD: begin
        if (ph_zero) begin
          nxt     = ST_HIGH;
          ph_load = 1'b1;
          ph_val  = HALF_V;
        end
      end
      ST_HIGH: begin
        if (ph_zero) begin
          nxt     = ST_HOLD;
          ph_load = 1'b1;
          ph_val  = HD_V;
        end
      end
      ST_HOLD: begin
        if (ph_zero) begin
          shift   = 1'b1;
          ph_load = 1'b1;
          if (bits_left != '0) begin
            nxt    = ST_LEAD;
            ph_val = LEAD_V;
          end else begin
            nxt    = ST_LESET;
            ph_val = LES_V;
          end
        end
      end
      ST_LESET: begin
        if (ph_zero) begin
          nxt      = ST_LATCH;
          ph_load  = 1'b1;
          ph_val   = PW_V;
          gap_load = 1'b1;
        end
      end
      ST_LATCH: begin
        if (ph_zero) begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bits_left <= '0;
      sclk      <= 1'b0;
      le        <= 1'b0;
    end else begin
      state <= nxt;
      sclk  <= (nxt == ST_HIGH);
      le    <= (nxt == ST_LATCH);
      if (accept) begin
        bits_left <= BC_W'(WORD_W - 1);
      end else if (state == ST_HOLD && ph_zero && bits_left != '0) begin
        bits_left <= bits_left - 1'b1;
      end
    end
  end

endmodule

// File: rtl/atten_ser_master.sv
module atten_ser_master
  import atten_ser_pkg::*;
#(
  parameter int CLK_MHZ       = 250,
  parameter int SCLK_HALF_NS  = 50,
  parameter int DATA_SU_NS    = 10,
  parameter int DATA_HD_NS    = 10,
  parameter int LE_SU_NS      = 10,
  parameter int LE_PW_NS      = 30,
  parameter int UPDATE_GAP_NS = 40000,
  parameter int CODE_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              in_ready,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_le
);

  localparam int WORD_W   = CODE_W + 1;
  localparam int HALF_CYC = ns_to_cyc(SCLK_HALF_NS, CLK_MHZ);
  localparam int SU_CYC   = ns_to_cyc(DATA_SU_NS, CLK_MHZ);
  localparam int HD_CYC   = ns_to_cyc(DATA_HD_NS, CLK_MHZ);
  localparam int LES_CYC  = ns_to_cyc(LE_SU_NS, CLK_MHZ);
  localparam int PW_CYC   = ns_to_cyc(LE_PW_NS, CLK_MHZ);
  localparam int GAP_CYC  = ns_to_cyc(UPDATE_GAP_NS, CLK_MHZ);
  localparam int LEAD_CYC = max2(max2(HALF_CYC - HD_CYC, SU_CYC), 1);
  localparam int PH_MAX   = max2(max2(max2(LEAD_CYC, HALF_CYC), max2(HD_CYC, LES_CYC)), PW_CYC);
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int GAP_W    = $clog2(GAP_CYC + 1);

  logic            accept;
  logic            ph_load, ph_zero;
  logic [PH_W-1:0] ph_val;
  logic            shift;
  logic            gap_load, gap_zero;

  atten_ser_fsm #(
    .WORD_W  (WORD_W),
    .PH_W    (PH_W),
    .LEAD_CYC(LEAD_CYC),
    .HALF_CYC(HALF_CYC),
    .HD_CYC  (HD_CYC),
    .LES_CYC (LES_CYC),
    .PW_CYC  (PW_CYC)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .gap_zero(gap_zero),
    .ph_zero (ph_zero),
    .in_ready(in_ready),
    .accept  (accept),
    .ph_load (ph_load),
    .ph_val  (ph_val),
    .shift   (shift),
    .gap_load(gap_load),
    .sclk    (ser_clk),
    .le      (ser_le)
  );

  atten_ser_timer #(.W(PH_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ph_load),
    .load_val(ph_val),
    .zero    (ph_zero)
  );

  atten_ser_timer #(.W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .load_val(GAP_W'(GAP_CYC)),
    .zero    (gap_zero)
  );

  atten_ser_shreg #(.CODE_W(CODE_W)) u_shreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .code   (in_code),
    .shift  (shift),
    .bit_out(ser_data)
  );

endmodule

// File: rtl/atten_ser_chk.sv
module atten_ser_chk #(
  parameter int HALF_CYC = 13,
  parameter int GAP_CYC  = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_le
);

  localparam int HW = $clog2(HALF_CYC + 2);
  localparam int GW = $clog2(GAP_CYC + 2);

  logic [HW-1:0] hi_cnt;
  logic [GW-1:0] gap_cnt;
  logic          le_d;
  logic          seen_le;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      gap_cnt <= '0;
      le_d    <= 1'b0;
      seen_le <= 1'b0;
    end else begin
      le_d <= ser_le;
      if (!ser_clk) hi_cnt <= '0;
      else if (hi_cnt < HW'(HALF_CYC)) hi_cnt <= hi_cnt + 1'b1;
      if (ser_le && !le_d) begin
        gap_cnt <= GW'(1);
        seen_le <= 1'b1;
      end else if (gap_cnt < GW'(GAP_CYC)) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R1

  AST_CLK_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_clk && hi_cnt != '0) |-> hi_cnt >= HW'(HALF_CYC)); // R3

  AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R4

  AST_LE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_le && !le_d) |-> !in_ready); // R5

  AST_LE_QUIET_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !ser_clk); // R6

  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_le && !le_d && seen_le) |-> gap_cnt >= GW'(GAP_CYC)); // R7

  AST_IDLE_REST: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!ser_clk && !ser_data && !ser_le)); // R8

endmodule

bind atten_ser_master atten_ser_chk #(
  .HALF_CYC(HALF_CYC),
  .GAP_CYC (GAP_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .ser_clk (ser_clk),
  .ser_data(ser_data),
  .ser_le  (ser_le)
);

// File: tb/atten_ser_master_test.sv
module atten_ser_master_test;

  localparam int MHZ    = 250;
  localparam int T_HALF = (50 * MHZ + 999) / 1000;
  localparam int T_SU   = (10 * MHZ + 999) / 1000;
  localparam int T_HD   = (10 * MHZ + 999) / 1000;
  localparam int T_LES  = (10 * MHZ + 999) / 1000;
  localparam int T_PW   = (30 * MHZ + 999) / 1000;
  localparam int T_GAP  = (40000 * MHZ + 999) / 1000;
  localparam int WDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] in_code = '0;
  logic       in_ready, ser_clk, ser_data, ser_le;

  always #2 clk = ~clk;

  atten_ser_master uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_code (in_code),
    .in_ready(in_ready),
    .ser_clk (ser_clk),
    .ser_data(ser_data),
    .ser_le  (ser_le)
  );

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int latched = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  logic [5:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: hold the code until accepted, then push the expected word.
  task automatic send(input logic [4:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = c;
    while (!in_ready) @(negedge clk);
    exp_q.push_back({1'b0, c});
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready, "R1", "ready low after accept", int'(in_ready), 0);
  endtask

  // Monitor / scoreboard
  longint t = 0;
  longint t_clk_rise = -1000000, t_clk_fall = -1000000;
  longint t_data = -1000000, t_le_rise = -1000000;
  bit     has_le = 1'b0;
  int     nbits = 0;
  logic [5:0] cap = '0;
  logic p_clk = 1'b0, p_data = 1'b0, p_le = 1'b0, p_rdy = 1'b0;

  always @(negedge clk) begin
    if (mon_en && !done) begin
      t++;
      if (ser_data != p_data) begin
        if (p_clk && ser_clk)
          check(1'b0, "R4", "data changed with clock high", 1, 0);
        else if (nbits > 0)
          check(t - t_clk_fall >= T_HD, "R4", "hold after fall",
                int'(t - t_clk_fall), T_HD);
        t_data = t;
      end
      if (ser_clk && !p_clk) begin
        check(t - t_clk_fall >= T_HALF, "R3", "clock low time",
              int'(t - t_clk_fall), T_HALF);
        check(t - t_data >= T_SU, "R4", "setup before rise",
              int'(t - t_data), T_SU);
        check(!ser_le, "R5", "latch low while shifting", int'(ser_le), 0);
        cap = {cap[4:0], ser_data};
        nbits++;
        t_clk_rise = t;
      end
      if (!ser_clk && p_clk) begin
        check(t - t_clk_rise >= T_HALF, "R3", "clock high time",
              int'(t - t_clk_rise), T_HALF);
        t_clk_fall = t;
      end
      if (ser_le && !p_le) begin
        check(t - t_clk_fall >= T_LES, "R5", "latch after last fall",
              int'(t - t_clk_fall), T_LES);
        check(nbits == 6, "R5", "bits before latch", nbits, 6);
        if (has_le)
          check(t - t_le_rise >= T_GAP, "R7", "latch spacing",
                int'(t - t_le_rise), T_GAP);
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "latch with no accepted code", int'(cap), -1);
        end else begin
          logic [5:0] e;
          e = exp_q.pop_front();
          check(cap == e, "R2", "latched word", int'(cap), int'(e));
        end
        latched++;
        nbits = 0;
        has_le = 1'b1;
        t_le_rise = t;
      end
      if (ser_le)
        check(!ser_clk, "R6", "clock low during latch", int'(ser_clk), 0);
      if (!ser_le && p_le)
        check(t - t_le_rise >= T_PW, "R6", "latch pulse width",
              int'(t - t_le_rise), T_PW);
      if (in_ready && !p_rdy && has_le) begin
        check(t - t_le_rise == T_GAP, "R7", "ready return after latch",
              int'(t - t_le_rise), T_GAP);
        check(!ser_clk && !ser_data && !ser_le, "R8", "idle outputs",
              int'({ser_clk, ser_data, ser_le}), 0);
      end
    end
    p_clk  = ser_clk;
    p_data = ser_data;
    p_le   = ser_le;
    p_rdy  = in_ready;
  end

  // Watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", WDOG, 0);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check({ser_clk, ser_data, ser_le} == 3'b000, "R8", "outputs in reset",
          int'({ser_clk, ser_data, ser_le}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    p_rdy  = in_ready;
    mon_en = 1'b1;
    check(in_ready, "R8", "ready after reset", int'(in_ready), 1);
    check({ser_clk, ser_data, ser_le} == 3'b000, "R8", "idle after reset",
          int'({ser_clk, ser_data, ser_le}), 0);

    send(5'h00);
    send(5'h1F);
    send(5'h01);
    send(5'h10);
    // R1: a different code pulsed only while busy must never go out
    begin
      bit stayed_low;
      stayed_low = 1'b1;
      @(negedge clk);
      in_valid = 1'b1;
      in_code  = 5'h07;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (in_ready) stayed_low = 1'b0;
      end
      in_valid = 1'b0;
      check(stayed_low, "R1", "ready low while code offered busy",
            int'(stayed_low), 1);
    end
    // R1: held across busy, transmitted once
    send(5'h15);
    send(5'h0A);
    send(5'h11);

    while (!(in_ready && exp_q.size() == 0)) @(negedge clk);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R1", "pending words", exp_q.size(), 0);
    check(latched == sent, "R1", "latch count", latched, sent);
    check({ser_clk, ser_data, ser_le} == 3'b000, "R8", "final idle",
          int'({ser_clk, ser_data, ser_le}), 0);
    finish_run();
  end

endmodule